// File: doc/BRIEF.md
# Pin-Change Interrupt Merger

This block collects change events from a group of input pins and merges them into one interrupt request line for the processor's interrupt controller. Each pin has its own enable bit and its own trigger direction: one setting makes a rising transition the trigger, the other makes a falling transition the trigger. Enabled, direction-corrected pin levels are ORed into one source level. A rising transition of that source sets a pending request. The request stays set until the controller acknowledges it. Firmware then reads the pins to find out which one fired, because the block keeps no per-pin record and gives no pin priority over another.

Because the merged source is a level, a pin that has fired and is still at its active level keeps the OR high. No other pin can raise a new request until that pin returns to its inactive level or its enable is removed. A global enable masks the request line without discarding the pending state. An alternate mode hands the request to a parallel host-interface engine. In that mode every pin is masked and the engine's own request level becomes the source, whatever the per-pin enables are. Pin inputs cross into the clock domain through a synchroniser chain, and the edge detection runs in the system clock domain.

Top module: `pin_irq_aggregator`

## Requirements
- R1: While reset is high and in the first cycle after it, `irq_o` is 0 and no request is pending.
- R2: A pin whose `pin_pol_i` bit is 1 triggers on a 0-to-1 transition. A pin whose `pin_pol_i` bit is 0 triggers on a 1-to-0 transition. The inactive level is therefore the inverse of the polarity bit.
- R3: A pin whose `pin_en_i` bit is 0 never sets a request, whatever it does.
- R4: While any enabled pin is at its active level, other pins reaching their active level set no new request. A new trigger is possible again once every enabled pin is inactive, or once the active pin's enable bit has been cleared.
- R5: A pending request stays set until `ack_i` is high at a clock edge. If a new source edge arrives in the same cycle as `ack_i`, the request stays set.
- R6: `irq_o` is the pending request ANDed with `glob_en_i`. A request that arrives while `glob_en_i` is 0 is kept, and it appears on `irq_o` when `glob_en_i` goes to 1.
- R7: While `alt_mode_i` is 1, pin activity sets no request. A 0-to-1 transition of `alt_req_i` sets the request even when every `pin_en_i` bit is 0.
- R8: A pin transition at the input appears on `irq_o` at the (SYNC_STAGES+1)-th rising clock edge after it. A rising `alt_req_i` appears at the first rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_i | input | NUM_PINS | Asynchronous pin levels |
| pin_en_i | input | NUM_PINS | Per-pin enable, 1 = pin may trigger |
| pin_pol_i | input | NUM_PINS | Per-pin trigger direction, 1 = rising, 0 = falling |
| glob_en_i | input | 1 | Global enable gating the request output |
| alt_mode_i | input | 1 | 1 = host-interface engine owns the request, pins masked |
| alt_req_i | input | 1 | Request level from the host-interface engine, synchronous |
| ack_i | input | 1 | Interrupt acknowledge, clears the pending request |
| irq_o | output | 1 | Merged interrupt request |

## Verification
The bench builds the block with NUM_PINS = 4 and SYNC_STAGES = 2. With four pins, all-ones and all-zeros enable and polarity vectors and mixed polarity patterns can be written out in full. With two synchroniser stages, the three-edge pin latency can be checked on the exact cycle where the request rises. The alternate-mode path has a single edge of latency, so the bench uses it to place a source edge and an acknowledge in the same cycle.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    typedef enum logic {
        SRC_PINS = 1'b0,
        SRC_ALT  = 1'b1
    } irq_src_e;

    typedef struct packed {
        logic pend;
        logic src_d;
    } latch_state_t;

    // Level after direction correction: active when it matches the polarity bit.
    function automatic logic pin_active(input logic level, input logic pol);
        return level ^ ~pol;
    endfunction

endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic             run_q;

    always_ff @(posedge clk) begin
        if (rst) run_q <= 1'b0;
        else     run_q <= 1'b1;
    end

    genvar k;
    generate
        for (k = 0; k < STAGES; k++) begin : g_stage
            if (k == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '0;
                    else     stage_q[0] <= d_i;
                end
                p_sync_first_r8: assert property (@(posedge clk) disable iff (rst)
                    run_q |-> stage_q[0] == $past(d_i))
                    else $error("first synchroniser stage lost a sample");
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) stage_q[k] <= '0;
                    else     stage_q[k] <= stage_q[k-1];
                end
                p_sync_chain_r8: assert property (@(posedge clk) disable iff (rst)
                    run_q |-> stage_q[k] == $past(stage_q[k-1]))
                    else $error("synchroniser chain skipped a stage");
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pin_irq_qualify.sv
module pin_irq_qualify
    import pin_irq_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] level_i,
    input  logic [WIDTH-1:0] en_i,
    input  logic [WIDTH-1:0] pol_i,
    output logic             any_o
);
    logic [WIDTH-1:0] hit;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_pin
            assign hit[i] = en_i[i] & pin_active(level_i[i], pol_i[i]);
        end
    endgenerate

    assign any_o = |hit;

    always_comb begin
        if (en_i == '0) p_disabled_quiet_r3: assert (!any_o)
            else $error("merged source high with all pins disabled");
    end
endmodule

// File: rtl/pin_irq_latch.sv
module pin_irq_latch
    import pin_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic src_i,
    input  logic ack_i,
    output logic pend_o
);
    latch_state_t st_q, st_d;
    logic         rise;

    assign rise = src_i & ~st_q.src_d;

    always_comb begin
        st_d       = st_q;
        st_d.src_d = src_i;
        if (rise)       st_d.pend = 1'b1;
        else if (ack_i) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    p_set_on_edge_r5: assert property (@(posedge clk) disable iff (rst)
        (src_i && !st_q.src_d) |=> pend_o)
        else $error("source edge did not set the request");

    p_hold_until_ack_r5: assert property (@(posedge clk) disable iff (rst)
        (pend_o && !ack_i) |=> pend_o)
        else $error("request dropped without acknowledge");

    p_rise_has_cause_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_o) |-> st_q.src_d)
        else $error("request rose without a source edge");
endmodule

// File: rtl/pin_irq_aggregator.sv
module pin_irq_aggregator
    import pin_irq_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic [NUM_PINS-1:0] pin_en_i,
    input  logic [NUM_PINS-1:0] pin_pol_i,
    input  logic                glob_en_i,
    input  logic                alt_mode_i,
    input  logic                alt_req_i,
    input  logic                ack_i,
    output logic                irq_o
);
    localparam int SYNC_DEPTH = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    logic [NUM_PINS-1:0] pin_sync;
    logic                pin_any;
    logic                src;
    logic                pend;
    irq_src_e            owner;

    pin_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pin_i),
        .q_o (pin_sync)
    );

    pin_irq_qualify #(.WIDTH(NUM_PINS)) u_qual (
        .level_i (pin_sync),
        .en_i    (pin_en_i),
        .pol_i   (pin_pol_i),
        .any_o   (pin_any)
    );

    assign owner = alt_mode_i ? SRC_ALT : SRC_PINS;

    always_comb begin
        unique case (owner)
            SRC_ALT:  src = alt_req_i;
            default:  src = pin_any;
        endcase
    end

    pin_irq_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .src_i  (src),
        .ack_i  (ack_i),
        .pend_o (pend)
    );

    assign irq_o = pend & glob_en_i;

    p_global_gate_r6: assert property (@(posedge clk) disable iff (rst)
        !glob_en_i |-> !irq_o)
        else $error("request visible while globally disabled");

    p_alt_masks_pins_r7: assert property (@(posedge clk) disable iff (rst)
        (alt_mode_i && !alt_req_i && !pend && !ack_i) |=> !pend || $past(alt_mode_i && alt_req_i))
        else $error("pin activity raised a request in alternate mode");
endmodule

// File: tb/tb_pin_irq_aggregator.sv
module tb_pin_irq_aggregator;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] pin, en, pol;
    logic         glob, mode, areq, ack;
    logic         irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pin_irq_aggregator #(.NUM_PINS(N), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .pin_i(pin), .pin_en_i(en), .pin_pol_i(pol),
        .glob_en_i(glob), .alt_mode_i(mode), .alt_req_i(areq), .ack_i(ack),
        .irq_o(irq)
    );

    typedef struct packed {
        logic [N-1:0] p0;
        logic [N-1:0] p1;
        logic [N-1:0] en;
        logic [N-1:0] pol;
        logic         glob;
        logic         mode;
        logic         a0;
        logic         a1;
        logic         exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{4'b0000, 4'b0001, 4'b1111, 4'b1111, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 rising
        '{4'b1111, 4'b1110, 4'b1111, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 falling
        '{4'b0000, 4'b0001, 4'b1110, 4'b1111, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 disabled
        '{4'b0001, 4'b0011, 4'b1111, 4'b1111, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 blocked
        '{4'b0000, 4'b0011, 4'b1111, 4'b1111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 gated
        '{4'b0000, 4'b1111, 4'b1111, 4'b1111, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 pins masked
        '{4'b0000, 4'b0000, 4'b0000, 4'b1111, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}, // R7 alt fires
        '{4'b0000, 4'b0000, 4'b1111, 4'b1111, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R6 alt gated
        '{4'b1010, 4'b1000, 4'b1111, 4'b0101, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 mixed falling
        '{4'b1010, 4'b1011, 4'b1111, 4'b0101, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}  // R2 mixed rising
    };

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: irq_o=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic ack_pulse();
        ack = 1'b1;
        cyc(1);
        ack = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; pin = '0; en = '1; pol = '1;
        glob = 1'b1; mode = 1'b0; areq = 1'b0; ack = 1'b0;
        cyc(3);
        check("R1 in reset", irq, 1'b0);
        rst = 1'b0;
        cyc(1);
        check("R1 after reset", irq, 1'b0);

        // Vector table: settle p0, clear, then move to p1.
        for (int v = 0; v < NV; v++) begin
            pin = VECS[v].p0; en = VECS[v].en; pol = VECS[v].pol;
            glob = VECS[v].glob; mode = VECS[v].mode; areq = VECS[v].a0;
            cyc(5);
            ack_pulse();
            cyc(2);
            pin = VECS[v].p1; areq = VECS[v].a1;
            cyc(5);
            check($sformatf("R2/R3/R4/R6/R7 vector %0d", v), irq, VECS[v].exp);
        end

        // R8: pin latency of three edges with two sync stages.
        mode = 1'b0; glob = 1'b1; en = '1; pol = '1; pin = '0; areq = 1'b0;
        cyc(5); ack_pulse(); cyc(2);
        pin = 4'b0100;
        cyc(2);
        check("R8 not yet after two edges", irq, 1'b0);
        cyc(1);
        check("R8 set on third edge", irq, 1'b1);

        // R5: held without acknowledge, cleared by it.
        cyc(6);
        check("R5 held", irq, 1'b1);
        ack_pulse();
        check("R5 cleared by ack", irq, 1'b0);

        // R4: release active pin, another pin re-arms.
        pin = 4'b0000;
        cyc(5);
        pin = 4'b0010;
        cyc(4);
        check("R4 re-arm after release", irq, 1'b1);
        ack_pulse();

        // R4: disabling the active pin re-arms.
        en = 4'b1101;
        cyc(4);
        check("R4 no request on disable", irq, 1'b0);
        pin = 4'b0011;
        cyc(4);
        check("R4 re-arm after disable", irq, 1'b1);
        ack_pulse();

        // R6: request kept while globally disabled.
        pin = '0; en = '1;
        cyc(5); ack_pulse();
        glob = 1'b0;
        pin = 4'b1000;
        cyc(5);
        check("R6 masked", irq, 1'b0);
        glob = 1'b1;
        cyc(1);
        check("R6 appears when enabled", irq, 1'b1);
        ack_pulse();

        // R5/R8: alternate edge and ack in the same cycle.
        pin = '0; mode = 1'b1; areq = 1'b0;
        cyc(5); ack_pulse(); cyc(1);
        check("R7 idle", irq, 1'b0);
        areq = 1'b1; ack = 1'b1;
        cyc(1);
        ack = 1'b0;
        check("R5 edge wins over ack", irq, 1'b1);
        check("R8 alt one-edge latency", irq, 1'b1);
        ack_pulse();
        check("R5 plain ack clears", irq, 1'b0);

        // R1: reset drops a pending request.
        areq = 1'b0; cyc(1); areq = 1'b1; cyc(1);
        rst = 1'b1; cyc(1);
        check("R1 reset clears pending", irq, 1'b0);
        rst = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule